// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block sits between up to 24 interrupt request lines and an 8-bit microcontroller core. Software sets it up through a small register port: four enable registers and two level registers. A request takes part in arbitration only when its line is pending, its own enable bit is set and the master enable is set. The sources form six groups of four neighbouring lines. Each group gets a 2-bit level from 0 (lowest) to 3 (highest). The highest level wins. When levels are equal, the lowest source index wins, both between groups and inside a group.

The result is registered once per clock and shown to the core as a request flag, the index of the winning source and the vector address of its handler. When the core accepts the interrupt, at the start of its next instruction, it pulses an acknowledge. The block then marks the winner's level as in service. From then on only a request with a strictly higher level can interrupt it. A return strobe from the core clears the highest in-service level. Peripherals clear their own pending flags; this block does not.

Top module: `irq_group_arb`

## Requirements
- R1: After reset, every configuration register and the in-service set read back as 0x00, and `irq_req` is low.
- R2: Select codes are 0 to 3 for the enable registers, 4 for the level low bits, 5 for the level high bits and 6 for the in-service set. Enable register k holds the enables of sources 6k to 6k+5 in bits 5:0, and register 0 also holds the master enable in bit 7. The level registers hold groups 0 to 5 in bits 5:0. Bits not listed here read 0. Select 6 is read-only and ignores writes. A write takes effect at the next clock.
- R3: A source can win only when its pending line is high, its enable bit is set and the master enable is set.
- R4: The level of group g is {bit g of select 5, bit g of select 4}. Group g holds sources 4g to 4g+3. A higher level beats a lower one, whatever the indices.
- R5: Among eligible sources of equal level, the lowest source index wins, both between groups and inside one group.
- R6: While `irq_req` is high, `irq_src` gives the winning index and `irq_vec` equals 0x0003 + 8 × `irq_src`.
- R7: The outputs are registered: a change on `irq_pend` shows on the outputs one clock later, not in the same cycle.
- R8: An acknowledge while `irq_req` is high sets bit L of the in-service set, where L is the winner's level, and drives `irq_req` low at that clock edge.
- R9: A source is blocked while any in-service bit at its own level or above is set.
- R10: A return strobe clears the highest set bit of the in-service set. When the same strobe arrives together with an acknowledge, the clear happens first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data (combinational from rd_sel) |
| irq_pend | input | 24 | Pending request lines, one per source |
| cpu_ack | input | 1 | Acknowledge pulse from the core |
| cpu_reti | input | 1 | Return-from-interrupt pulse from the core |
| irq_req | output | 1 | Interrupt request to the core |
| irq_src | output | 5 | Index of the winning source |
| irq_vec | output | 16 | Handler vector address of the winning source |

## Verification
A single pending line is tried with the master enable off, then with its own enable off, then with both on. This shows that each gate blocks the request alone. Pairs of lines in different groups at equal level, and pairs inside one group, check the lowest-index rule. The same pairs with a raised group level show that level overrides index, and a case with every line pending confirms the overall winner. A nesting sequence on three groups at levels 1, 2 and 3 acknowledges and returns in turn. It shows that a request at the same level stays blocked, that a higher level gets through, and that each return drops exactly the top in-service level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // two-bit group level, four levels in total
  localparam int unsigned LVL_W = 2;
  localparam int unsigned N_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [N_LVL-1:0] isr_t;
endpackage

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned NSRC    = 24,
  parameter int unsigned PER_REG = 6,
  parameter int unsigned NGRP    = 6,
  parameter int unsigned SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  input  isr_t             isr,
  output logic [7:0]       rd_data,
  output logic [NSRC-1:0]  en_mask,
  output logic             glb_en,
  output logic [NGRP-1:0]  lvl_lo,
  output logic [NGRP-1:0]  lvl_hi
);
  localparam int unsigned NREG    = NSRC / PER_REG;
  localparam int unsigned SEL_LO  = NREG;
  localparam int unsigned SEL_HI  = NREG + 1;
  localparam int unsigned SEL_ISR = NREG + 2;

  logic [NSRC-1:0] en_q, en_d;
  logic            glb_q, glb_d;
  logic [NGRP-1:0] lo_q, lo_d, hi_q, hi_d;
  logic            unused_wr;

  assign unused_wr = &{1'b0, wr_data[6:PER_REG]};

  // next-state
  always_comb begin
    en_d  = en_q;
    glb_d = glb_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    for (int r = 0; r < NREG; r++) begin
      if (wr_sel == SEL_W'(r)) en_d[r*PER_REG +: PER_REG] = wr_data[PER_REG-1:0];
    end
    if (wr_sel == '0)             glb_d = wr_data[7];
    if (wr_sel == SEL_W'(SEL_LO)) lo_d  = wr_data[NGRP-1:0];
    if (wr_sel == SEL_W'(SEL_HI)) hi_d  = wr_data[NGRP-1:0];
  end

  // registers, write strobe as clock enable
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q  <= '0;
      glb_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (wr_en) begin
      en_q  <= en_d;
      glb_q <= glb_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_sel == SEL_W'(r)) rd_data[PER_REG-1:0] = en_q[r*PER_REG +: PER_REG];
    end
    if (rd_sel == '0)              rd_data[7]        = glb_q;
    if (rd_sel == SEL_W'(SEL_LO))  rd_data[NGRP-1:0] = lo_q;
    if (rd_sel == SEL_W'(SEL_HI))  rd_data[NGRP-1:0] = hi_q;
    if (rd_sel == SEL_W'(SEL_ISR)) rd_data[N_LVL-1:0] = isr;
  end

  assign en_mask = en_q;
  assign glb_en  = glb_q;
  assign lvl_lo  = lo_q;
  assign lvl_hi  = hi_q;
endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned NSRC  = 24,
  parameter int unsigned GSZ   = 4,
  parameter int unsigned NGRP  = 6,
  parameter int unsigned IDX_W = 5
) (
  input  logic [NSRC-1:0]  elig,
  input  logic [NGRP-1:0]  lvl_lo,
  input  logic [NGRP-1:0]  lvl_hi,
  input  isr_t             isr,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx,
  output lvl_t             win_lvl
);
  lvl_t            src_lvl [NSRC];
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] hit [N_LVL];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_lvl[i] = {lvl_hi[i/GSZ], lvl_lo[i/GSZ]};
    // no in-service bit at or above this source's level
    assign cand[i]    = elig[i] && ((isr >> src_lvl[i]) == '0);
    for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
      assign hit[l][i] = cand[i] && (src_lvl[i] == LVL_W'(l));
    end
  end

  // last writer wins: highest level, then lowest index
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int l = 0; l < N_LVL; l++) begin
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (hit[l][i]) begin
          win_valid = 1'b1;
          win_idx   = IDX_W'(i);
          win_lvl   = LVL_W'(l);
        end
      end
    end
  end
endmodule

// File: rtl/irq_arb_isr.sv
module irq_arb_isr
  import irq_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_s,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output isr_t isr
);
  isr_t isr_q, isr_d, top_bit;

  // one-hot of the highest set bit
  always_comb begin
    top_bit = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if (isr_q[l]) top_bit = isr_t'(1) << l;
    end
  end

  always_comb begin
    isr_d = isr_q;
    if (pop)  isr_d = isr_d & ~top_bit;
    if (push) isr_d[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)          isr_q <= '0;
    else if (push | pop) isr_q <= isr_d;
  end

  assign isr = isr_q;
endmodule

// File: rtl/irq_group_arb.sv
module irq_group_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NSRC     = 24,
  parameter int unsigned GSZ      = 4,
  parameter int unsigned PER_REG  = 6,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int unsigned VEC_STEP = 8,
  localparam int unsigned NGRP    = NSRC / GSZ,
  localparam int unsigned NREG    = NSRC / PER_REG,
  localparam int unsigned IDX_W   = $clog2(NSRC),
  localparam int unsigned SEL_W   = $clog2(NREG + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [7:0]       rd_data,
  input  logic [NSRC-1:0]  irq_pend,
  input  logic             cpu_ack,
  input  logic             cpu_reti,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_src,
  output logic [15:0]      irq_vec
);
  logic [1:0]       rst_pipe;
  logic             rst_s;
  logic [NSRC-1:0]  en_mask, elig;
  logic             glb_en;
  logic [NGRP-1:0]  lvl_lo, lvl_hi;
  isr_t             isr_q;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;
  logic             req_q, req_d;
  logic [IDX_W-1:0] idx_q;
  lvl_t             lvl_q;
  logic [15:0]      vec_q, vec_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  irq_arb_regs #(
    .NSRC(NSRC), .PER_REG(PER_REG), .NGRP(NGRP), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_s(rst_s), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .isr(isr_q), .rd_data(rd_data), .en_mask(en_mask),
    .glb_en(glb_en), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi)
  );

  assign elig = irq_pend & en_mask & {NSRC{glb_en}};

  irq_arb_pick #(
    .NSRC(NSRC), .GSZ(GSZ), .NGRP(NGRP), .IDX_W(IDX_W)
  ) u_pick (
    .elig(elig), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .isr(isr_q),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_arb_isr u_isr (
    .clk(clk), .rst_s(rst_s), .push(cpu_ack & req_q), .push_lvl(lvl_q),
    .pop(cpu_reti), .isr(isr_q)
  );

  // next-state of the registered result
  always_comb begin
    req_d = win_valid & ~cpu_ack;
    vec_d = VEC_BASE + 16'(win_idx) * 16'(VEC_STEP);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      req_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      req_q <= req_d;
      idx_q <= win_idx;
      lvl_q <= win_lvl;
      vec_q <= vec_d;
    end
  end

  assign irq_req = req_q;
  assign irq_src = idx_q;
  assign irq_vec = vec_q;
endmodule

// File: rtl/irq_group_arb_chk.sv
module irq_group_arb_chk #(
  parameter int unsigned IDX_W    = 5,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int unsigned VEC_STEP = 8
) (
  input logic             clk,
  input logic             rst_s,
  input logic             cpu_ack,
  input logic             cpu_reti,
  input logic             irq_req,
  input logic [IDX_W-1:0] irq_src,
  input logic [15:0]      irq_vec,
  input logic [3:0]       isr,
  input logic             glb_en
);
  // R6: vector tracks the source index
  a_r6_vector: assert property (@(posedge clk) disable iff (!rst_s)
    irq_req |-> (irq_vec == VEC_BASE + 16'(irq_src) * 16'(VEC_STEP)));

  // R3: no request without the master enable one clock earlier
  a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_s)
    irq_req |-> $past(glb_en));

  // R8: acknowledge drops the request
  a_r8_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_s)
    cpu_ack |=> !irq_req);

  // R8: acknowledge of a live request adds one in-service level
  a_r8_ack_marks: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_ack && irq_req && !cpu_reti) |=> ($countones(isr) == $past($countones(isr)) + 1));

  // R10: return removes exactly one in-service level
  a_r10_reti_pops: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_reti && !cpu_ack && (isr != 4'b0)) |=> ($countones(isr) == $past($countones(isr)) - 1));
endmodule

bind irq_group_arb irq_group_arb_chk #(
  .IDX_W(IDX_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rst_s(rst_s), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
  .irq_req(irq_req), .irq_src(irq_src), .irq_vec(irq_vec), .isr(isr_q),
  .glb_en(glb_en)
);

// File: tb/sim_irq_group_arb.sv
module sim_irq_group_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic [23:0] irq_pend = '0;
  logic        cpu_ack = 1'b0;
  logic        cpu_reti = 1'b0;
  logic        irq_req;
  logic [4:0]  irq_src;
  logic [15:0] irq_vec;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_group_arb u0 (.*);

  typedef struct packed {
    logic [23:0] pend;
    logic [7:0]  e0, e1, e2, e3, plo, phi;
    logic        req;
    logic [4:0]  src;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{24'h000020, 8'hBF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 5'd5},  // R3 all gates open
    '{24'h000020, 8'h3F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 5'd0},  // R3 master off
    '{24'h000080, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 5'd0},  // R3 own enable off
    '{24'h100008, 8'hBF, 8'h3F, 8'h3F, 8'h3F, 8'h00, 8'h00, 1'b1, 5'd3},  // R5 across groups
    '{24'h100008, 8'hBF, 8'h3F, 8'h3F, 8'h3F, 8'h00, 8'h20, 1'b1, 5'd20}, // R4 level 2 beats 0
    '{24'h000600, 8'hBF, 8'h3F, 8'h3F, 8'h3F, 8'h00, 8'h00, 1'b1, 5'd9},  // R5 inside group
    '{24'h001001, 8'hBF, 8'h3F, 8'h3F, 8'h3F, 8'h01, 8'h08, 1'b1, 5'd12}, // R4 level 2 beats 1
    '{24'hFFFFFF, 8'hBF, 8'h3F, 8'h3F, 8'h3F, 8'h3F, 8'h3F, 1'b1, 5'd0},  // R5 all pending
    '{24'h800000, 8'h80, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 1'b1, 5'd23}, // R6 top index
    '{24'h000000, 8'hBF, 8'h3F, 8'h3F, 8'h3F, 8'h00, 8'h00, 1'b0, 5'd0},  // R3 nothing pending
    '{24'h00F004, 8'hBF, 8'h3F, 8'h3F, 8'h3F, 8'h08, 8'h00, 1'b1, 5'd12}  // R4 level 1 beats 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic pulse_reti();
    @(negedge clk); cpu_reti = 1'b1;
    @(negedge clk); cpu_reti = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_win(input string tag, input logic [4:0] s);
    chk({tag, " req"}, 32'(irq_req), 32'd1);
    chk({tag, " src"}, 32'(irq_src), 32'(s));
    chk({tag, " vec"}, 32'(irq_vec), 32'h3 + 32'd8 * 32'(s));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    irq_pend = '1;
    settle();
    for (int s = 0; s < 7; s++) begin
      rd(3'(s), d);
      chk($sformatf("R1 reg %0d", s), 32'(d), 32'h0);
    end
    chk("R1 req", 32'(irq_req), 32'd0);
    irq_pend = '0;

    // R2: field layout and unused bits
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R2 en1", 32'(d), 32'h3F);
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R2 en0", 32'(d), 32'hBF);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R2 lo", 32'(d), 32'h3F);
    wr(3'd5, 8'hFF); rd(3'd5, d); chk("R2 hi", 32'(d), 32'h3F);
    wr(3'd6, 8'hFF); rd(3'd6, d); chk("R2 isr ro", 32'(d), 32'h00);

    // vector table: R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      wr(3'd0, TBL[k].e0); wr(3'd1, TBL[k].e1);
      wr(3'd2, TBL[k].e2); wr(3'd3, TBL[k].e3);
      wr(3'd4, TBL[k].plo); wr(3'd5, TBL[k].phi);
      irq_pend = TBL[k].pend;
      settle();
      if (TBL[k].req) chk_win($sformatf("R3-5 vec %0d", k), TBL[k].src);
      else chk($sformatf("R3 vec %0d req", k), 32'(irq_req), 32'd0);
    end

    // R7: one clock of latency
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    irq_pend = '0;
    settle();
    @(negedge clk);
    irq_pend = 24'h000002;
    #1 chk("R7 same cycle", 32'(irq_req), 32'd0);
    @(negedge clk);
    chk_win("R7 next cycle", 5'd1);

    // R8 R9 R10: nesting with group levels 1, 2, 3
    wr(3'd4, 8'h05); wr(3'd5, 8'h06);
    irq_pend = 24'h000001;
    settle(); chk_win("R8 level1", 5'd0);
    pulse_ack();
    chk("R8 req drop", 32'(irq_req), 32'd0);
    rd(3'd6, d); chk("R8 isr l1", 32'(d), 32'h02);
    settle(); chk("R9 same level blocked", 32'(irq_req), 32'd0);
    irq_pend = 24'h000011;
    settle(); chk_win("R9 level2 nests", 5'd4);
    pulse_ack();
    rd(3'd6, d); chk("R8 isr l2", 32'(d), 32'h06);
    irq_pend = 24'h000111;
    settle(); chk_win("R9 level3 nests", 5'd8);
    pulse_ack();
    rd(3'd6, d); chk("R8 isr l3", 32'(d), 32'h0E);
    settle(); chk("R9 top blocked", 32'(irq_req), 32'd0);
    pulse_reti();
    rd(3'd6, d); chk("R10 pop l3", 32'(d), 32'h06);
    settle(); chk_win("R10 l3 again", 5'd8);
    pulse_reti(); pulse_reti();
    rd(3'd6, d); chk("R10 pop all", 32'(d), 32'h00);
    settle(); chk_win("R10 empty", 5'd8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule